// File: doc/BRIEF.md
# Slot-Sequenced Multi-Write Register File

This block gives a register file several independent write ports and several read ports. The storage behind them is a single array with one address port. The block runs on one fast clock. A free-running slot counter splits every base cycle into `NRD + NWR` slots. At a base-cycle boundary the block takes in one request from every port and holds it in local registers. It then plays the held requests into the array one slot at a time. Reads go first and writes follow, in ascending port order.

The block marks the final slot of each base cycle with a registered strobe, `base_tick`. A client logic in the slower base domain uses this strobe as its clock enable, so no divided or gated clock exists anywhere. Read results are gathered in return registers and presented together at the next boundary. A read therefore always sees the contents as they stood before the writes of its own batch.

Top module: `tdm_mwrite_rf`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `base_tick` is 0 and every `rd_data` lane is 0.
- R2: The slot counter starts at slot 0 when reset is released and counts up to `NRD+NWR-1`, then wraps to 0. `base_tick` is high for exactly one cycle in every `NRD+NWR`, during the final slot. Its first high cycle is the `NRD+NWR`-th cycle after reset release.
- R3: The port inputs are sampled only at the rising edge where `base_tick` is high. Values presented in any other cycle have no effect on the storage or on `rd_data`.
- R4: A read address sampled at boundary edge k returns its data on `rd_data` just after boundary edge k+1. The data stays there until edge k+2.
- R5: A read and a write to the same address in the same batch return the value from before that write (write-after-read order). The new value is returned by a read in a later batch.
- R6: Writes of one batch are applied in ascending port order. When several enabled ports target one address, the highest-numbered of them leaves its data stored.
- R7: A write port whose enable bit is 0 in a batch leaves the storage unchanged, whatever its address and data.
- R8: `rd_data` changes only on the clock edge at which `base_tick` is high.
- R9: Port lanes are packed by index. Write port i uses `wr_en[i]`, `wr_addr[i*AW +: AW]` and `wr_data[i*DW +: DW]`. Read port j uses `rd_addr[j*AW +: AW]` and `rd_data[j*DW +: DW]`, where `AW = $clog2(DEPTH)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all slots and the base cycle run on it |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | NWR | Write enable per write port |
| wr_addr | input | NWR*AW | Packed write addresses |
| wr_data | input | NWR*DW | Packed write data |
| rd_addr | input | NRD*AW | Packed read addresses |
| base_tick | output | 1 | High in the final slot; the edge that ends it is the base-cycle boundary |
| rd_data | output | NRD*DW | Packed read results, registered, updated at each boundary |

## Verification
On every cycle, the assertions check the following:
- the slot counter steps and wraps as R2 requires, and the strobe never lasts two cycles;
- the held requests do not move between boundaries;
- `rd_data` holds between boundaries;
- the array is written only in write slots, which is what keeps reads ahead of writes.

The data-dependent rules need the bench's scenarios and its behavioural model of stored contents:
- a read and a write colliding on one address in one batch (R5);
- several ports writing one address (R6);
- masked writes (R7);
- junk driven between boundaries (R3).

// File: rtl/tdm_rf_pkg.sv
package tdm_rf_pkg;
  // Number of slots in one base cycle: every read port and every write port
  // gets exactly one slot on the single physical array port.
  function automatic int slot_total(input int nrd, input int nwr);
    return nrd + nwr;
  endfunction
endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq #(
  parameter int NSLOT = 5,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [SW-1:0] slot_o,
  output logic          last_o
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic [SW-1:0] slot_q, slot_nxt;
  logic          last_q;

  always_comb begin
    slot_nxt = (slot_q == LAST) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      last_q <= 1'b0;
    end else begin
      slot_q <= slot_nxt;
      last_q <= (slot_nxt == LAST);
    end
  end

  assign slot_o = slot_q;
  assign last_o = last_q;

  // R2: counter stays in range, steps by one, wraps to zero
  a_r2_range: assert property (@(posedge clk) disable iff (rst) slot_q <= LAST);
  a_r2_wrap:  assert property (@(posedge clk) disable iff (rst)
                (slot_q == LAST) |=> (slot_q == '0));
  a_r2_step:  assert property (@(posedge clk) disable iff (rst)
                (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
  // R2: strobe is a single-cycle pulse
  a_r2_pulse: assert property (@(posedge clk) disable iff (rst)
                last_q |=> !last_q);
endmodule

// File: rtl/tdm_req_latch.sv
module tdm_req_latch #(
  parameter int NWR = 3,
  parameter int NRD = 2,
  parameter int AW  = 4,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NWR-1:0]    we_i,
  input  logic [NWR*AW-1:0] wa_i,
  input  logic [NWR*DW-1:0] wd_i,
  input  logic [NRD*AW-1:0] ra_i,
  output logic [NWR-1:0]    we_o,
  output logic [NWR*AW-1:0] wa_o,
  output logic [NWR*DW-1:0] wd_o,
  output logic [NRD*AW-1:0] ra_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_o <= '0;
      wa_o <= '0;
      wd_o <= '0;
      ra_o <= '0;
    end else if (load) begin
      we_o <= we_i;
      wa_o <= wa_i;
      wd_o <= wd_i;
      ra_o <= ra_i;
    end
  end

  // R3: held batch does not move between boundaries
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
               !load |=> ($stable(we_o) && $stable(wa_o) && $stable(wd_o) && $stable(ra_o)));
endmodule

// File: rtl/tdm_store_ram.sv
module tdm_store_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  // Single-port, read-first synchronous array so block RAM can be inferred.
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tdm_mwrite_rf.sv
module tdm_mwrite_rf
  import tdm_rf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  parameter int NWR   = 3,
  parameter int NRD   = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NWR-1:0]    wr_en,
  input  logic [NWR*AW-1:0] wr_addr,
  input  logic [NWR*DW-1:0] wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic              base_tick,
  output logic [NRD*DW-1:0] rd_data
);
  localparam int NSLOT = slot_total(NRD, NWR);
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [SW-1:0]     slot;
  logic              tick;
  logic [NWR-1:0]    we_q;
  logic [NWR*AW-1:0] wa_q;
  logic [NWR*DW-1:0] wd_q;
  logic [NRD*AW-1:0] ra_q;
  logic              phy_we;
  logic [AW-1:0]     phy_addr;
  logic [DW-1:0]     phy_wd;
  logic [DW-1:0]     ram_q;
  logic              rdv_q;
  logic [SW-1:0]     rdi_q;
  logic [NRD*DW-1:0] stage_q, stage_nxt, rd_data_q;

  tdm_slot_seq #(.NSLOT(NSLOT)) u_seq (
    .clk(clk), .rst(rst), .slot_o(slot), .last_o(tick)
  );

  tdm_req_latch #(.NWR(NWR), .NRD(NRD), .AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst(rst), .load(tick),
    .we_i(wr_en), .wa_i(wr_addr), .wd_i(wr_data), .ra_i(rd_addr),
    .we_o(we_q), .wa_o(wa_q), .wd_o(wd_q), .ra_o(ra_q)
  );

  // Slot steering: read slots first, then write slots in port order.
  always_comb begin
    phy_we   = 1'b0;
    phy_addr = '0;
    phy_wd   = '0;
    for (int r = 0; r < NRD; r++) begin
      if (slot == SW'(r)) phy_addr = ra_q[r*AW +: AW];
    end
    for (int w = 0; w < NWR; w++) begin
      if (slot == SW'(NRD + w)) begin
        phy_addr = wa_q[w*AW +: AW];
        phy_we   = we_q[w];
        phy_wd   = wd_q[w*DW +: DW];
      end
    end
  end

  tdm_store_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(phy_we), .addr(phy_addr), .wdata(phy_wd), .rdata(ram_q)
  );

  // Return path: array output belongs to the read slot of the previous cycle.
  always_comb begin
    stage_nxt = stage_q;
    for (int j = 0; j < NRD; j++) begin
      if (rdv_q && (rdi_q == SW'(j))) stage_nxt[j*DW +: DW] = ram_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdv_q     <= 1'b0;
      rdi_q     <= '0;
      stage_q   <= '0;
      rd_data_q <= '0;
    end else begin
      rdv_q   <= (int'(slot) < NRD);
      rdi_q   <= slot;
      stage_q <= stage_nxt;
      if (tick) rd_data_q <= stage_nxt;
    end
  end

  assign base_tick = tick;
  assign rd_data   = rd_data_q;

  // R5: array is written only in write slots, after every read slot
  a_r5_write_slot: assert property (@(posedge clk) disable iff (rst)
                     phy_we |-> (int'(slot) >= NRD));
  // R8: results held between boundaries
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
                  !tick |=> $stable(rd_data_q));
  // R4: a read slot is never captured in the boundary slot's successor
  a_r4_ret_slot: assert property (@(posedge clk) disable iff (rst)
                   rdv_q |-> (int'(rdi_q) < NRD));
endmodule

// File: tb/tdm_mwrite_rf_tb.sv
module tdm_mwrite_rf_tb;
  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int NWR   = 3;
  localparam int NRD   = 2;
  localparam int AW    = $clog2(DEPTH);
  localparam int S     = NRD + NWR;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NWR-1:0]    wr_en = '0;
  logic [NWR*AW-1:0] wr_addr = '0;
  logic [NWR*DW-1:0] wr_data = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic              base_tick;
  logic [NRD*DW-1:0] rd_data;

  tdm_mwrite_rf #(.DEPTH(DEPTH), .DW(DW), .NWR(NWR), .NRD(NRD)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .base_tick(base_tick), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [DW-1:0] mdl [DEPTH];
  bit            kn  [DEPTH];
  logic [DW-1:0] pend_v [NRD];
  bit            pend_k [NRD];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle monitor: strobe period (R2) and result hold (R8)
  int n = 0;
  logic              prev_tick = 1'b0;
  logic [NRD*DW-1:0] prev_rd = '0;
  bit                mon_on = 0;
  always @(posedge clk) if (!rst) n <= n + 1;
  always @(negedge clk) begin
    if (mon_on && !done) begin
      chk(base_tick == ((n % S) == S - 1), "R2", base_tick, (n % S) == S - 1);
      if (rd_data != prev_rd) chk(prev_tick, "R8", rd_data, prev_rd);
    end
    prev_tick = base_tick;
    prev_rd   = rd_data;
  end

  task automatic batch(input string req, input logic [NWR-1:0] we,
                       input logic [NWR*AW-1:0] wa, input logic [NWR*DW-1:0] wd,
                       input logic [NRD*AW-1:0] ra);
    logic [DW-1:0] nv [NRD];
    bit            nk [NRD];
    while (!base_tick) @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    for (int j = 0; j < NRD; j++) begin
      nv[j] = mdl[ra[j*AW +: AW]];
      nk[j] = kn[ra[j*AW +: AW]];
    end
    for (int i = 0; i < NWR; i++) begin
      if (we[i]) begin
        mdl[wa[i*AW +: AW]] = wd[i*DW +: DW];
        kn[wa[i*AW +: AW]]  = 1;
      end
    end
    @(negedge clk);
    for (int j = 0; j < NRD; j++) begin
      if (pend_k[j]) chk(rd_data[j*DW +: DW] == pend_v[j], req, rd_data[j*DW +: DW], pend_v[j]);
      pend_v[j] = nv[j];
      pend_k[j] = nk[j];
    end
    // R3: junk between boundaries must be ignored
    wr_en   = '1;
    wr_addr = NWR*AW'($urandom);
    wr_data = {$urandom, $urandom, $urandom};
    rd_addr = NRD*AW'($urandom);
  endtask

  function automatic logic [NWR*AW-1:0] pa3(input int a0, input int a1, input int a2);
    return {AW'(a2), AW'(a1), AW'(a0)};
  endfunction
  function automatic logic [NWR*DW-1:0] pd3(input int d0, input int d1, input int d2);
    return {DW'(d2), DW'(d1), DW'(d0)};
  endfunction
  function automatic logic [NRD*AW-1:0] pr2(input int a0, input int a1);
    return {AW'(a1), AW'(a0)};
  endfunction

  initial begin
    for (int a = 0; a < DEPTH; a++) kn[a] = 0;
    for (int j = 0; j < NRD; j++) pend_k[j] = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(base_tick == 1'b0, "R1", base_tick, 0);
    chk(rd_data == '0, "R1", rd_data, 0);
    rst = 1'b0;
    mon_on = 1;
    @(negedge clk);
    chk(base_tick == 1'b0 && rd_data == '0, "R1", {base_tick, rd_data}, 0);

    // R9: fill every address through all three lanes
    for (int b = 0; b < 6; b++)
      batch("R9", 3'b111, pa3((3*b) % DEPTH, (3*b+1) % DEPTH, (3*b+2) % DEPTH),
            pd3(16'h1000 + 3*b, 16'h2000 + 3*b + 1, 16'h3000 + 3*b + 2), pr2(b, 15 - b));
    batch("R4", 3'b000, '0, '0, pr2(0, 1));
    batch("R4", 3'b000, '0, '0, pr2(14, 15));
    // R5: read and write of address 5 in one batch returns old data
    batch("R4", 3'b001, pa3(5, 0, 0), pd3(16'hBEEF, 0, 0), pr2(5, 5));
    batch("R5", 3'b000, '0, '0, pr2(5, 6));
    batch("R5", 3'b000, '0, '0, pr2(5, 5));
    // R6: three ports on address 7, port 2 must remain
    batch("R5", 3'b111, pa3(7, 7, 7), pd3(16'hA0A0, 16'hB1B1, 16'hC2C2), pr2(8, 9));
    batch("R6", 3'b011, pa3(9, 9, 7), pd3(16'h1111, 16'h2222, 16'h3333), pr2(7, 7));
    batch("R6", 3'b000, '0, '0, pr2(9, 7));
    // R7: masked writes leave address 3 alone
    batch("R6", 3'b000, pa3(3, 3, 3), pd3(16'hDEAD, 16'hDEAD, 16'hDEAD), pr2(3, 4));
    batch("R7", 3'b000, '0, '0, pr2(3, 3));
    batch("R7", 3'b000, '0, '0, pr2(3, 4));
    // R3: random traffic with junk between every boundary
    for (int k = 0; k < 40; k++)
      batch("R3", NWR'($urandom), NWR*AW'($urandom), {$urandom, $urandom, $urandom},
            NRD*AW'($urandom));
    for (int a = 0; a < DEPTH; a += 2) batch("R3", 3'b000, '0, '0, pr2(a, a + 1));
    batch("R4", 3'b000, '0, '0, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule